// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

This block is a memory-mapped periodic timer built around a down counter, 24 bits wide by default. Software programs it through a simple 32-bit register bus that has a 4-bit byte address, a write strobe, a read strobe, write data and combinational read data. The bus reaches four word registers:

| Offset | Register | Contents |
|--------|----------|----------|
| 0x0 | control/status | control bits and the wrap flag |
| 0x4 | reload value | value loaded when the count is zero |
| 0x8 | current count | live count value |
| 0xC | calibration word | read-only, fixed by parameters |

Once the enable bit is set, the counter moves on every tick. A tick is either every core clock or each cycle in which the one-cycle reference enable input is high, as a control bit selects. When the counter reaches zero it reloads from the reload register on the next tick. Each pass from one to zero latches a wrap flag and can raise a one-cycle interrupt pulse.

The count is run by a small state machine with three states:

- CNT_HALT: counting is disabled.
- CNT_ZERO: the counter is enabled and holds zero. The next tick loads the reload value.
- CNT_DOWN: the counter is enabled and holds a non-zero count. Each tick decrements it.

The next state is chosen after the next count and the next enable value are known. Its transitions are:

- go_halt: any state moves to CNT_HALT when the enable clears.
- go_zero: the counter enters CNT_ZERO when the next count is zero, whether from a decrement out of one, a clear, or a reload of zero.
- go_down: the counter enters CNT_DOWN when the next count is non-zero.

Top module: `periodic_dntimer`

## Requirements
- R1: After reset the control/status, reload and current-count registers read zero and the interrupt output is low.
- R2: Register decode uses address bits 3:2.
  - Offset 0x0 is control/status: bit 0 enable, bit 1 interrupt enable, bit 2 source (1 = core clock, 0 = reference enable), bit 16 wrap flag.
  - Offset 0x4 is the reload value.
  - Offset 0x8 is the current count.
  - Offset 0xC is the calibration word.
  - Reload and count read back their low 24 bits, with the upper bits zero.
- R3: While enabled, each tick decrements a non-zero count by one, and a tick at count zero loads the reload value.
- R4: With the source bit at 1 every clock is a tick. With the source bit at 0 only the cycles where the reference enable is high are ticks.
- R5: A reload value of zero keeps an enabled counter at zero and never sets the wrap flag.
- R6: A write of any data to offset 0x8 sets the count to zero and clears the wrap flag. It takes precedence over a tick in the same cycle.
- R7: The wrap flag is set when a tick moves the count from 1 to 0. A read of offset 0x0 clears it. A set in the same cycle as such a read wins, so the flag stays 1.
- R8: With interrupt enable at 1, the interrupt output is high for exactly the one cycle after the edge at which the count passes from 1 to 0. With interrupt enable at 0 it stays low.
- R9: The calibration word returns bit 31 = reference absent, bit 30 = inexact 10 ms value, and bits 23:0 = ticks per 10 ms, all from parameters. Writes to it are ignored.
- R10: When built without a reference, a source bit of 0 never advances the counter, whatever the reference input does.
- R11: With enable at 0 the count holds. Writes to bit 16 of offset 0x0 do not change the wrap flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | core clock |
| rst_ni | input | 1 | active-low synchronous reset |
| ref_tick_i | input | 1 | one-cycle reference tick enable |
| addr_i | input | 4 | register byte address |
| wr_en_i | input | 1 | register write strobe |
| rd_en_i | input | 1 | register read strobe (clears the flag when it reads offset 0x0) |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for the addressed register |
| irq_o | output | 1 | one-cycle interrupt request |

## Verification
Two functions can land on the same clock edge. The first pair is the wrap flag being set by a 1-to-0 tick and being cleared by a control read. The second pair is a count-clearing write and the wrap tick it pre-empts. The bench steps the core-clock counter until its own model holds a count of 1, then issues the control read or the count write in exactly that cycle. For the read, a following control read must still show the flag set. For the write, the flag must stay clear and no interrupt pulse may follow. Long seeded random runs of mixed reads, writes and reference patterns make these collisions happen again by chance, and each result is compared with the bench's model.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_CALIB   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CNT_HALT = 2'd0,
        CNT_ZERO = 2'd1,
        CNT_DOWN = 2'd2
    } cnt_state_e;

    localparam int BIT_EN    = 0;
    localparam int BIT_IE    = 1;
    localparam int BIT_SRC   = 2;
    localparam int BIT_FLAG  = 16;
    localparam int BIT_SKEW  = 30;
    localparam int BIT_NOREF = 31;
endpackage

// File: rtl/pdt_tick_sel.sv
module pdt_tick_sel #(
    parameter bit HAS_REF = 1'b1
) (
    input  logic src_core_i,
    input  logic ref_tick_i,
    output logic tick_o
);
    localparam logic REF_OK = HAS_REF;

    // core source ticks every cycle; reference ticks only if one exists
    assign tick_o = src_core_i | (ref_tick_i & REF_OK);
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter
    import pdt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_q_i,
    input  logic             en_next_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        cnt_n = cnt_q;
        unique case (state_q)
            CNT_HALT: cnt_n = cnt_q;
            CNT_ZERO: if (tick_i) cnt_n = reload_i;
            CNT_DOWN: if (tick_i) cnt_n = cnt_q - ONE;
            default:  cnt_n = cnt_q;
        endcase
        if (clr_i) cnt_n = '0;

        if (!en_next_i)        state_n = CNT_HALT;   // go_halt
        else if (cnt_n == '0)  state_n = CNT_ZERO;   // go_zero
        else                   state_n = CNT_DOWN;   // go_down
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= CNT_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (state_q == CNT_DOWN) && tick_i && !clr_i && (cnt_q == ONE);

    // R11: halted state tracks the enable register held elsewhere
    p_halt_tracks_en_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CNT_HALT) == !en_q_i);
    p_hold_when_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CNT_HALT && !clr_i) |=> (cnt_q == $past(cnt_q)));
    p_dec_by_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CNT_DOWN && tick_i && !clr_i) |=> (cnt_q == $past(cnt_q) - ONE));
    p_zero_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CNT_ZERO && tick_i && !clr_i) |=> (cnt_q == $past(reload_i)));
    p_clear_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pdt_regs.sv
module pdt_regs
    import pdt_pkg::*;
#(
    parameter int          CNT_W   = 24,
    parameter bit          HAS_REF = 1'b1,
    parameter bit          SKEW    = 1'b0,
    parameter int unsigned TENMS   = 10000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  reg_sel_e          sel_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wrap_i,
    output logic              en_q_o,
    output logic              en_next_o,
    output logic              src_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              clr_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic             en_q, ie_q, src_q, flag_q, irq_q;
    logic [CNT_W-1:0] reload_q;
    logic             wr_ctrl, wr_reload, rd_ctrl;
    logic             unused_hi;

    assign wr_ctrl   = wr_en_i && (sel_i == SEL_CTRL);
    assign wr_reload = wr_en_i && (sel_i == SEL_RELOAD);
    assign clr_o     = wr_en_i && (sel_i == SEL_CURRENT);
    assign rd_ctrl   = rd_en_i && (sel_i == SEL_CTRL);
    assign unused_hi = ^wdata_i[DATA_W-1:CNT_W];

    assign en_next_o = wr_ctrl ? wdata_i[BIT_EN] : en_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q     <= 1'b0;
            ie_q     <= 1'b0;
            src_q    <= 1'b0;
            flag_q   <= 1'b0;
            irq_q    <= 1'b0;
            reload_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= wdata_i[BIT_EN];
                ie_q  <= wdata_i[BIT_IE];
                src_q <= wdata_i[BIT_SRC];
            end
            if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
            if (wrap_i)                  flag_q <= 1'b1;
            else if (clr_o || rd_ctrl)   flag_q <= 1'b0;
            irq_q <= wrap_i && ie_q;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel_i)
            SEL_CTRL: begin
                rdata_o[BIT_EN]   = en_q;
                rdata_o[BIT_IE]   = ie_q;
                rdata_o[BIT_SRC]  = src_q;
                rdata_o[BIT_FLAG] = flag_q;
            end
            SEL_RELOAD:  rdata_o[CNT_W-1:0] = reload_q;
            SEL_CURRENT: rdata_o[CNT_W-1:0] = cnt_i;
            SEL_CALIB: begin
                rdata_o[BIT_NOREF]  = !HAS_REF;
                rdata_o[BIT_SKEW]   = SKEW;
                rdata_o[CNT_W-1:0]  = CNT_W'(TENMS);
            end
            default: rdata_o = '0;
        endcase
    end

    assign en_q_o   = en_q;
    assign src_o    = src_q;
    assign reload_o = reload_q;
    assign irq_o    = irq_q;

    p_flag_after_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i |=> flag_q);
    p_irq_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_q |=> !irq_q);
    p_irq_with_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_q |-> flag_q);
endmodule

// File: rtl/periodic_dntimer.sv
module periodic_dntimer
    import pdt_pkg::*;
#(
    parameter int          CNT_W   = 24,
    parameter bit          HAS_REF = 1'b1,
    parameter bit          SKEW    = 1'b0,
    parameter int unsigned TENMS   = 10000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        ref_tick_i,
    input  logic [3:0]  addr_i,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        irq_o
);
    reg_sel_e         sel;
    logic             en_q, en_next, src, tick, clr, wrap;
    logic [CNT_W-1:0] reload, cnt;
    logic             unused_lsb;

    assign sel        = reg_sel_e'(addr_i[ADDR_W-1:2]);
    assign unused_lsb = ^addr_i[1:0];

    pdt_tick_sel #(.HAS_REF(HAS_REF)) u_tick (
        .src_core_i (src),
        .ref_tick_i (ref_tick_i),
        .tick_o     (tick)
    );

    pdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_q_i    (en_q),
        .en_next_i (en_next),
        .tick_i    (tick),
        .clr_i     (clr),
        .reload_i  (reload),
        .cnt_o     (cnt),
        .wrap_o    (wrap)
    );

    pdt_regs #(.CNT_W(CNT_W), .HAS_REF(HAS_REF), .SKEW(SKEW), .TENMS(TENMS)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_i     (sel),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .wdata_i   (wdata_i),
        .cnt_i     (cnt),
        .wrap_i    (wrap),
        .en_q_o    (en_q),
        .en_next_o (en_next),
        .src_o     (src),
        .reload_o  (reload),
        .clr_o     (clr),
        .irq_o     (irq_o),
        .rdata_o   (rdata_o)
    );
endmodule

// File: tb/periodic_dntimer_bench.sv
module periodic_dntimer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_t = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_nr;
    logic        irq, irq_nr;

    int n_tests = 0;
    int n_fail  = 0;

    logic [23:0] m_cnt, m_rel;
    bit          m_en, m_ie, m_src, m_flag, m_irq;

    always #5 clk = ~clk;

    periodic_dntimer u_periodic_dntimer (
        .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_t), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq));

    periodic_dntimer #(.HAS_REF(1'b0), .SKEW(1'b1), .TENMS(500)) u_periodic_dntimer_noref (
        .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_t), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
        .rdata_o(rdata_nr), .irq_o(irq_nr));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a[3:2])
            2'd0: return {15'b0, m_flag, 13'b0, m_src, m_ie, m_en};
            2'd1: return {8'b0, m_rel};
            2'd2: return {8'b0, m_cnt};
            default: return 32'h0000_2710;
        endcase
    endfunction

    task automatic model_step(input bit w, input bit r, input logic [3:0] a,
                              input logic [31:0] d, input bit rt);
        bit          tk, set, clrw;
        logic [23:0] n;
        tk   = m_en && (m_src || rt);
        clrw = w && (a[3:2] == 2'd2);
        set  = 1'b0;
        n    = m_cnt;
        if (clrw) n = '0;
        else if (tk) begin
            if (m_cnt == 0) n = m_rel;
            else begin
                if (m_cnt == 1) set = 1'b1;
                n = m_cnt - 24'd1;
            end
        end
        m_irq = set && m_ie;
        if (set) m_flag = 1'b1;
        else if (clrw || (r && a[3:2] == 2'd0)) m_flag = 1'b0;
        if (w && a[3:2] == 2'd0) begin
            m_en = d[0]; m_ie = d[1]; m_src = d[2];
        end
        if (w && a[3:2] == 2'd1) m_rel = d[23:0];
        m_cnt = n;
    endtask

    task automatic do_cycle(input bit w, input bit r, input logic [3:0] a,
                            input logic [31:0] d, input bit rt, input string tag);
        wr_en = w; rd_en = r; addr = a; wdata = d; ref_t = rt;
        #1;
        if (r) check(tag, rdata, model_read(a));
        @(posedge clk);
        model_step(w, r, a, d, rt);
        @(negedge clk);
        check("R8 irq", {31'b0, irq}, {31'b0, m_irq});
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic idle(input int n, input bit rt);
        for (int i = 0; i < n; i++) do_cycle(0, 0, 4'h0, 32'h0, rt, "idle");
    endtask

    task automatic run_to_one();
        for (int i = 0; i < 100 && m_cnt != 24'd1; i++) idle(1, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_cnt = '0; m_rel = '0; m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R9 calibration
        check("R1 irq", {31'b0, irq}, 32'h0);
        do_cycle(0, 1, 4'h0, 0, 0, "R1 ctrl");
        do_cycle(0, 1, 4'h4, 0, 0, "R1 reload");
        do_cycle(0, 1, 4'h8, 0, 0, "R1 count");
        do_cycle(0, 1, 4'hC, 0, 0, "R9 calib");
        wr_en = 0; rd_en = 1; addr = 4'hC; #1;
        check("R9 calib noref", rdata_nr, 32'hC000_01F4);
        do_cycle(1, 0, 4'hC, 32'hFFFF_FFFF, 0, "R9");
        do_cycle(0, 1, 4'hC, 0, 0, "R9 calib after write");

        // R2 decode and field widths, R11 flag not writable
        do_cycle(1, 0, 4'h4, 32'hFFFF_FFFF, 0, "R2");
        do_cycle(0, 1, 4'h4, 0, 0, "R2 reload width");
        do_cycle(1, 0, 4'h0, 32'h0001_0000, 0, "R11");
        do_cycle(0, 1, 4'h0, 0, 0, "R11 flag not writable");

        // R3, R8 core-clock counting with interrupt
        do_cycle(1, 0, 4'h4, 32'd3, 0, "R3");
        do_cycle(1, 0, 4'h8, 32'hDEAD_BEEF, 0, "R6");
        do_cycle(1, 0, 4'h0, 32'h7, 0, "R3");
        for (int i = 0; i < 12; i++) do_cycle(0, 1, 4'h8, 0, 0, "R3 count");

        // R7 flag set collides with control read
        run_to_one();
        do_cycle(0, 1, 4'h0, 0, 0, "R7 read at wrap");
        do_cycle(0, 1, 4'h0, 0, 0, "R7 flag survives");
        do_cycle(0, 1, 4'h0, 0, 0, "R7 flag cleared");

        // R6 count write collides with wrap tick
        run_to_one();
        do_cycle(1, 0, 4'h8, 32'h1234_5678, 0, "R6");
        do_cycle(0, 1, 4'h0, 0, 0, "R6 flag clear");
        do_cycle(0, 1, 4'h8, 0, 0, "R6 count zero");

        // R4 reference source
        do_cycle(1, 0, 4'h4, 32'd5, 0, "R4");
        do_cycle(1, 0, 4'h0, 32'h3, 0, "R4");
        for (int i = 0; i < 20; i++) do_cycle(0, 1, 4'h8, 0, (i % 3) == 0, "R4 ref count");

        // R5 zero reload
        do_cycle(1, 0, 4'h4, 32'd0, 0, "R5");
        do_cycle(1, 0, 4'h8, 32'd0, 0, "R5");
        do_cycle(1, 0, 4'h0, 32'h7, 0, "R5");
        idle(6, 1'b1);
        do_cycle(0, 1, 4'h8, 0, 0, "R5 stays zero");
        do_cycle(0, 1, 4'h0, 0, 0, "R5 no flag");

        // R11 disabled hold
        do_cycle(1, 0, 4'h4, 32'd9, 0, "R11");
        idle(4, 1'b0);
        do_cycle(1, 0, 4'h0, 32'h4, 0, "R11");
        idle(5, 1'b1);
        do_cycle(0, 1, 4'h8, 0, 0, "R11 count held");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned op = $urandom_range(0, 9);
            logic [3:0]  a  = {$urandom_range(0, 3), 2'b00};
            logic [31:0] d  = $urandom();
            bit          rt = $urandom_range(0, 2) == 0;
            string       tg;
            if (a[3:2] == 2'd1) d = $urandom_range(0, 7);
            case (a[3:2])
                2'd0: tg = "R7 ctrl";
                2'd1: tg = "R2 reload";
                2'd2: tg = "R3 count";
                default: tg = "R9 calib";
            endcase
            if (op < 4)       do_cycle(0, 1, a, 0, rt, tg);
            else if (op == 4) do_cycle(1, 0, a, d, rt, tg);
            else              do_cycle(0, 0, 4'h0, 0, rt, tg);
        end

        // R10 no reference: source 0 never advances the reference-less copy
        do_cycle(1, 0, 4'h4, 32'd5, 0, "R10");
        do_cycle(1, 0, 4'h8, 32'd0, 0, "R10");
        do_cycle(1, 0, 4'h0, 32'h1, 0, "R10");
        idle(8, 1'b1);
        wr_en = 0; rd_en = 1; addr = 4'h8; #1;
        check("R10 noref count", rdata_nr, 32'h0);
        do_cycle(0, 1, 4'h8, 0, 1, "R4 ref count");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule